// File: doc/BRIEF.md
# Packet-Level Ingress Bus Receiver

This block takes fixed-length packets from an upstream packet engine over a 32-bit synchronous bus and stores them in an internal word FIFO. A downstream consumer reads them back through a valid/ready word port. The receiver offers a single enable line to the sender. The enable is driven from FIFO free space alone. Pacing happens between whole packets, never between words: once a start-of-packet strobe is accepted, one word is taken on every clock until the fixed length is reached.

Two flow-control modes are selectable by a static input. In handshake mode, a packet starts only when the start strobe comes with the sender's packet-available flag. In in-band mode, the available flag is ignored, and a packet whose first word carries the idle marker is thrown away instead of stored. Every bus input and the enable output pass through a register, so each side reacts two clocks after the other. A packet becomes visible to the reader only after its last word has been written, and a sticky error flag records framing misuse.

Top module: `pkt_ingress_rx`

## Requirements
- R1: During and right after reset, `up_enable`, `rd_valid` and `proto_err` are 0 and `rd_pkt_cnt` is 0.
- R2: Outside a packet, `up_enable` is 1 exactly when the FIFO has at least `PKT_WORDS` free words. The level of `up_avail` does not affect it, so the enable is high after reset while `up_avail` is low.
- R3: In handshake mode (`inband_mode`=0), a packet starts with a word that has `up_sop`=1 and `up_avail`=1. That word is word 0, and the next `PKT_WORDS`-1 clocks each carry one more word. A start strobe without `up_avail` is ignored, and its words are not stored.
- R4: While a packet is being received, `up_enable` holds the value it had in the cycle of word 1 through word `PKT_WORDS`-4. In the cycle of word `PKT_WORDS`-3, which is two clocks before the last word, it is 1 only if a further whole packet still fits after the current one.
- R5: Bus inputs and the enable are registered. The enable seen with word j was computed from word j-2. `rd_valid` for a packet in an empty FIFO rises two clocks after its last word was on the bus, and not one clock after.
- R6: In in-band mode (`inband_mode`=1), `up_avail` is ignored. A packet whose first word has bit `IDLE_BIT` (default 31) set is discarded. In handshake mode, that bit is ordinary data and the packet is stored.
- R7: Words are read in arrival order, and one word is removed on each clock where `rd_valid` and `rd_ready` are both 1. `rd_pkt_cnt` counts stored packets not yet fully read, and `rd_valid` is 1 only while it is non-zero.
- R8: A start strobe during a packet sets `proto_err`, which stays set until reset. That word is stored as an ordinary data word of the current packet.
- R9: A packet that starts while fewer than `PKT_WORDS` words are free is discarded whole and sets `proto_err`. Packets already stored are unaffected.
- R10: The FIFO never takes a write while it holds `FIFO_PKTS`*`PKT_WORDS` words, and `rd_pkt_cnt` never exceeds `FIFO_PKTS`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inband_mode | input | 1 | 0: handshake flow control, 1: in-band flow control |
| up_avail | input | 1 | Sender has a packet ready |
| up_sop | input | 1 | Marks word 0 of a packet |
| up_data | input | 32 | Bus data word |
| up_enable | output | 1 | Receiver can take a whole packet |
| rd_ready | input | 1 | Consumer takes the presented word |
| rd_valid | output | 1 | A stored word is presented |
| rd_data | output | 32 | Presented word |
| rd_pkt_cnt | output | $clog2(FIFO_PKTS+1) | Complete packets stored and not fully read |
| proto_err | output | 1 | Sticky framing error |

## Verification
The bound checker watches, on every clock, the properties that need no scenario. It checks that a write never lands in a full FIFO, that the packet count stays bounded and moves one step at a time, that a presented word implies stored data, and that the error flag never clears by itself. The exact cycle at which the enable drops near a packet's end, the hold of the enable through mid-packet words, the two-clock latency to `rd_valid`, and the word-for-word content and ordering of stored packets can only be shown by the bench. The same holds for idle-packet discard in one mode versus storage in the other, and for the discard of a packet that arrives with no room.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
    localparam int unsigned BUS_W = 32;

    typedef logic [BUS_W-1:0] word_t;

    typedef struct packed {
        logic  avail;
        logic  sop;
        word_t data;
    } bus_in_t;

    typedef enum logic {
        FC_HANDSHAKE = 1'b0,
        FC_INBAND    = 1'b1
    } fc_mode_e;
endpackage

// File: rtl/pkt_rx_in_reg.sv
module pkt_rx_in_reg
    import pkt_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  bus_in_t bus_raw,
    output bus_in_t bus_reg
);
    bus_in_t bus_d, bus_q;

    always_comb begin
        bus_d = bus_raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign bus_reg = bus_q;
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
    import pkt_rx_pkg::*;
#(
    parameter  int unsigned PKT_WORDS = 16,
    parameter  int unsigned FIFO_PKTS = 4,
    localparam int unsigned DEPTH     = PKT_WORDS * FIFO_PKTS,
    localparam int unsigned PTR_W     = $clog2(DEPTH),
    localparam int unsigned FILL_W    = $clog2(DEPTH + 1),
    localparam int unsigned CNT_W     = $clog2(FIFO_PKTS + 1),
    localparam int unsigned IDX_W     = $clog2(PKT_WORDS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  word_t             push_data,
    input  logic              commit,
    input  logic              pop,
    output logic              rd_valid,
    output word_t             rd_data,
    output logic [FILL_W-1:0] fill,
    output logic [CNT_W-1:0]  pkt_cnt
);
    typedef struct packed {
        logic [PTR_W-1:0]  wr_ptr;
        logic [PTR_W-1:0]  rd_ptr;
        logic [FILL_W-1:0] fill;
        logic [CNT_W-1:0]  pkt_cnt;
        logic [IDX_W-1:0]  rd_idx;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    word_t    mem [DEPTH];
    logic     pop_eff;
    logic     pop_last;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        pop_eff  = pop && (st_q.pkt_cnt != '0);
        pop_last = pop_eff && (st_q.rd_idx == IDX_W'(PKT_WORDS - 1));

        if (push) begin
            st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
        end
        if (pop_eff) begin
            st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
            st_d.rd_idx = pop_last ? '0 : st_q.rd_idx + 1'b1;
        end
        st_d.fill    = st_q.fill + FILL_W'(push) - FILL_W'(pop_eff);
        st_d.pkt_cnt = st_q.pkt_cnt + CNT_W'(commit) - CNT_W'(pop_last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[st_q.wr_ptr] <= push_data;
        end
    end

    assign rd_valid = (st_q.pkt_cnt != '0);
    assign rd_data  = mem[st_q.rd_ptr];
    assign fill     = st_q.fill;
    assign pkt_cnt  = st_q.pkt_cnt;
endmodule

// File: rtl/pkt_rx_frame.sv
module pkt_rx_frame
    import pkt_rx_pkg::*;
#(
    parameter  int unsigned PKT_WORDS = 16,
    parameter  int unsigned FIFO_PKTS = 4,
    parameter  int unsigned IDLE_BIT  = 31,
    localparam int unsigned DEPTH     = PKT_WORDS * FIFO_PKTS,
    localparam int unsigned FILL_W    = $clog2(DEPTH + 1),
    localparam int unsigned IDX_W     = $clog2(PKT_WORDS),
    localparam int          HOLD_LEAD = 5
)(
    input  logic              clk,
    input  logic              rst_n,
    input  fc_mode_e          mode,
    input  bus_in_t           bus,
    input  logic [FILL_W-1:0] fill,
    output logic              push,
    output word_t             push_data,
    output logic              commit,
    output logic              enable,
    output logic              err
);
    typedef struct packed {
        logic             in_pkt;
        logic [IDX_W-1:0] idx;
        logic             keep;
        logic             err;
        logic             enable;
    } frame_st_t;

    frame_st_t        st_d, st_q;
    logic             cur_valid;
    logic [IDX_W-1:0] cur_idx;
    logic             keep_now;
    logic             last;
    logic             room_start;
    logic             room_ok;
    logic             hold;
    int               reserve;

    always_comb begin
        st_d       = st_q;
        cur_valid  = 1'b0;
        cur_idx    = '0;
        keep_now   = st_q.keep;
        room_start = (int'(DEPTH) - int'(fill)) >= int'(PKT_WORDS);

        if (st_q.in_pkt) begin
            cur_valid = 1'b1;
            cur_idx   = st_q.idx;
            if (bus.sop) begin
                st_d.err = 1'b1;
            end
        end else if (bus.sop && (mode == FC_INBAND || bus.avail)) begin
            cur_valid = 1'b1;
            if (!room_start) begin
                keep_now = 1'b0;
                st_d.err = 1'b1;
            end else begin
                keep_now = !(mode == FC_INBAND && bus.data[IDLE_BIT]);
            end
        end

        last    = cur_valid && (cur_idx == IDX_W'(PKT_WORDS - 1));
        push    = cur_valid && keep_now;
        commit  = last && keep_now;
        reserve = (cur_valid && keep_now) ? int'(PKT_WORDS) - int'(cur_idx) : 0;
        room_ok = (int'(DEPTH) - int'(fill) - reserve) >= int'(PKT_WORDS);
        hold    = cur_valid && ((int'(cur_idx) + HOLD_LEAD) < int'(PKT_WORDS));

        st_d.enable = hold ? st_q.enable : room_ok;
        st_d.in_pkt = cur_valid && !last;
        st_d.idx    = (cur_valid && !last) ? cur_idx + 1'b1 : '0;
        st_d.keep   = keep_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_data = bus.data;
    assign enable    = st_q.enable;
    assign err       = st_q.err;
endmodule

// File: rtl/pkt_ingress_rx.sv
module pkt_ingress_rx
    import pkt_rx_pkg::*;
#(
    parameter  int unsigned PKT_WORDS = 16,
    parameter  int unsigned FIFO_PKTS = 4,
    parameter  int unsigned IDLE_BIT  = 31,
    localparam int unsigned DEPTH     = PKT_WORDS * FIFO_PKTS,
    localparam int unsigned FILL_W    = $clog2(DEPTH + 1),
    localparam int unsigned CNT_W     = $clog2(FIFO_PKTS + 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inband_mode,
    input  logic             up_avail,
    input  logic             up_sop,
    input  logic [31:0]      up_data,
    output logic             up_enable,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    output logic [CNT_W-1:0] rd_pkt_cnt,
    output logic             proto_err
);
    bus_in_t           bus_raw;
    bus_in_t           bus_reg;
    logic              fifo_push;
    word_t             fifo_wdata;
    logic              fifo_commit;
    logic [FILL_W-1:0] fifo_fill;

    assign bus_raw = '{avail: up_avail, sop: up_sop, data: up_data};

    pkt_rx_in_reg u_in_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_raw (bus_raw),
        .bus_reg (bus_reg)
    );

    pkt_rx_frame #(
        .PKT_WORDS (PKT_WORDS),
        .FIFO_PKTS (FIFO_PKTS),
        .IDLE_BIT  (IDLE_BIT)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (fc_mode_e'(inband_mode)),
        .bus       (bus_reg),
        .fill      (fifo_fill),
        .push      (fifo_push),
        .push_data (fifo_wdata),
        .commit    (fifo_commit),
        .enable    (up_enable),
        .err       (proto_err)
    );

    pkt_rx_fifo #(
        .PKT_WORDS (PKT_WORDS),
        .FIFO_PKTS (FIFO_PKTS)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (fifo_wdata),
        .commit    (fifo_commit),
        .pop       (rd_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .fill      (fifo_fill),
        .pkt_cnt   (rd_pkt_cnt)
    );
endmodule

// File: rtl/pkt_ingress_rx_chk.sv
module pkt_ingress_rx_chk #(
    parameter  int unsigned PKT_WORDS = 16,
    parameter  int unsigned FIFO_PKTS = 4,
    localparam int unsigned DEPTH     = PKT_WORDS * FIFO_PKTS,
    localparam int unsigned FILL_W    = $clog2(DEPTH + 1),
    localparam int unsigned CNT_W     = $clog2(FIFO_PKTS + 1)
)(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic [CNT_W-1:0]  rd_pkt_cnt,
    input logic              proto_err,
    input logic              fifo_push,
    input logic              fifo_commit,
    input logic [FILL_W-1:0] fifo_fill
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (int'(fifo_fill) < int'(DEPTH)));                       // R10

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_pkt_cnt) <= int'(FIFO_PKTS));                                 // R10

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown($past(rd_pkt_cnt)) |->
        (int'(rd_pkt_cnt) <= int'($past(rd_pkt_cnt)) + 1));                   // R7

    AST_COMMIT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_commit |=> (rd_pkt_cnt != '0));                                  // R7

    AST_VALID_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (fifo_fill != '0));                                      // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);                                             // R8
endmodule

bind pkt_ingress_rx pkt_ingress_rx_chk #(
    .PKT_WORDS (PKT_WORDS),
    .FIFO_PKTS (FIFO_PKTS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (rd_valid),
    .rd_pkt_cnt  (rd_pkt_cnt),
    .proto_err   (proto_err),
    .fifo_push   (fifo_push),
    .fifo_commit (fifo_commit),
    .fifo_fill   (fifo_fill)
);

// File: tb/pkt_ingress_rx_tb.sv
`timescale 1ns/1ps
module pkt_ingress_rx_tb;
    localparam int PW  = 16;
    localparam int NP  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inband_mode = 1'b0;
    logic        up_avail = 1'b0;
    logic        up_sop = 1'b0;
    logic [31:0] up_data = '0;
    logic        up_enable;
    logic        rd_ready = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [2:0]  rd_pkt_cnt;
    logic        proto_err;

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    int          rd_mode = 0;
    logic [31:0] exp_q [$];
    logic [31:0] cur_words [PW];
    logic        cur_en [PW];

    always #4 clk = ~clk;

    pkt_ingress_rx #(.PKT_WORDS(PW), .FIFO_PKTS(NP), .IDLE_BIT(31)) u_dut (
        .clk(clk), .rst_n(rst_n), .inband_mode(inband_mode),
        .up_avail(up_avail), .up_sop(up_sop), .up_data(up_data),
        .up_enable(up_enable), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_pkt_cnt(rd_pkt_cnt), .proto_err(proto_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit enable_expected(input int kept_before);
        return (NP * PW - (kept_before + 1) * PW) >= PW;
    endfunction

    function automatic bit is_kept(input logic [31:0] w0, input bit inband);
        return !(inband && w0[31]);
    endfunction

    // reader: consumes words and compares them with the expected stream
    initial begin
        forever begin
            @(negedge clk);
            if (rd_mode == 1)      rd_ready = ($urandom % 4) != 0;
            else if (rd_mode == 2) rd_ready = 1'b1;
            else                   rd_ready = 1'b0;
            if (rd_ready && rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected word", rd_data, 0);
                end else begin
                    check(rd_data == exp_q[0], "R7 word order", rd_data, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        up_sop = 1'b0; up_avail = 1'b0; up_data = '0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        check(up_enable == 1'b0 && rd_valid == 1'b0 && proto_err == 1'b0 && rd_pkt_cnt == 0,
              "R1 reset state", {up_enable, rd_valid, proto_err, rd_pkt_cnt}, 0);
        rst_n = 1'b1;
    endtask

    task automatic send_pkt(input int idle_sel, input bit obey, input bit avail_v, input int sop2);
        @(negedge clk);
        if (obey) while (!up_enable) @(negedge clk);
        for (int w = 0; w < PW; w++) begin
            if (w > 0) @(negedge clk);
            cur_en[w]    = up_enable;
            cur_words[w] = $urandom;
            if (w == 0 && idle_sel == 0) cur_words[w][31] = 1'b0;
            if (w == 0 && idle_sel == 1) cur_words[w][31] = 1'b1;
            up_sop   = (w == 0) || (w == sop2);
            up_avail = avail_v;
            up_data  = cur_words[w];
        end
        @(negedge clk);
        up_sop = 1'b0; up_avail = 1'b0; up_data = '0;
    endtask

    task automatic push_expected();
        for (int w = 0; w < PW; w++) exp_q.push_back(cur_words[w]);
    endtask

    task automatic drain();
        rd_mode = 2;
        for (int i = 0; i < 600 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0 && rd_valid == 1'b0, "R7 drained", exp_q.size(), 0);
        check(rd_pkt_cnt == 0, "R7 count empty", rd_pkt_cnt, 0);
        rd_mode = 0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        repeat (2) @(negedge clk);
        check(up_enable == 1'b1, "R2 enable with avail low", up_enable, 1);

        // fill the FIFO in handshake mode with the reader stalled
        for (int k = 0; k < NP; k++) begin
            send_pkt(2, 1'b1, 1'b1, -1);
            push_expected();
            if (k == 0) begin
                check(rd_valid == 1'b0, "R5 valid not one clock after last word", rd_valid, 0);
                @(negedge clk);
                check(rd_valid == 1'b1, "R5 valid two clocks after last word", rd_valid, 1);
            end
            for (int w = 2; w <= PW - 4; w++)
                check(cur_en[w] == cur_en[1], "R4 enable held mid-packet", cur_en[w], cur_en[1]);
            check(cur_en[PW-3] == enable_expected(k), "R4 enable two before last",
                  cur_en[PW-3], enable_expected(k));
        end
        repeat (2) @(negedge clk);
        check(rd_pkt_cnt == NP, "R7 packet count full", rd_pkt_cnt, NP);
        check(up_enable == 1'b0, "R2 enable low when full", up_enable, 0);
        check(proto_err == 1'b0, "R10 no error under obeyed enable", proto_err, 0);
        drain();
        check(up_enable == 1'b1, "R2 enable back after drain", up_enable, 1);

        // start strobe without avail in handshake mode is ignored
        send_pkt(0, 1'b0, 1'b0, -1);
        repeat (4) @(negedge clk);
        check(rd_pkt_cnt == 0 && rd_valid == 1'b0, "R3 sop without avail ignored", rd_pkt_cnt, 0);
        check(proto_err == 1'b0, "R3 no error for ignored sop", proto_err, 0);

        // idle marker is plain data in handshake mode
        send_pkt(1, 1'b1, 1'b1, -1);
        push_expected();
        repeat (2) @(negedge clk);
        check(rd_pkt_cnt == 1, "R6 idle kept in handshake mode", rd_pkt_cnt, 1);
        drain();

        // second start strobe mid-packet
        send_pkt(0, 1'b1, 1'b1, 5);
        push_expected();
        repeat (2) @(negedge clk);
        check(proto_err == 1'b1, "R8 mid-packet sop flagged", proto_err, 1);
        check(rd_pkt_cnt == 1, "R8 packet still stored", rd_pkt_cnt, 1);
        drain();
        check(proto_err == 1'b1, "R8 error sticky", proto_err, 1);
        do_reset();

        // in-band mode: avail ignored, idle packet dropped
        inband_mode = 1'b1;
        send_pkt(1, 1'b0, 1'b0, -1);
        send_pkt(0, 1'b0, 1'b0, -1);
        push_expected();
        repeat (2) @(negedge clk);
        check(rd_pkt_cnt == 1, "R6 idle dropped, normal kept", rd_pkt_cnt, 1);
        drain();

        // packet arriving with no room
        for (int k = 0; k < NP; k++) begin
            send_pkt(0, 1'b0, 1'b0, -1);
            push_expected();
        end
        check(proto_err == 1'b0, "R9 no error while room", proto_err, 0);
        send_pkt(0, 1'b0, 1'b0, -1);
        repeat (2) @(negedge clk);
        check(proto_err == 1'b1, "R9 no-room start flagged", proto_err, 1);
        check(rd_pkt_cnt == NP, "R9 no-room packet dropped", rd_pkt_cnt, NP);
        drain();
        do_reset();

        // random traffic in both modes with a stalling reader
        for (int m = 0; m < 2; m++) begin
            inband_mode = (m == 1);
            rd_mode = 1;
            for (int p = 0; p < 40; p++) begin
                repeat ($urandom % 4) @(negedge clk);
                send_pkt(2, 1'b1, 1'b1, -1);
                if (is_kept(cur_words[0], inband_mode)) push_expected();
            end
            drain();
            check(proto_err == 1'b0, "R10 random traffic error-free", proto_err, 0);
        end

        done = 1'b1;
        finish_run();
    end
endmodule